// File: doc/BRIEF.md
# Soft-Ramped Channel Volume Controller

This block applies digital gain to a multi-channel stream of signed audio samples. Each channel has its own 8-bit volume code. A shared master code is added to it as extra attenuation, unless the channel's bypass bit is set. The gain the block actually applies is held as a gain index. On every sample the index moves toward the target in 0.5 dB steps, instead of jumping to it.

The step pace comes from a 5-bit rate field. With the default setting of one step-count per sample at 96 kHz, the gain moves one step every `rate+1` samples, which is 48/(rate+1) dB per ms. Soft mute lowers the gain to silence along that ramp. Hard mute silences the output on the next sample. An optional zero-detect drops the gain to silence after a long run of zero input, so that the signal fades back in when audio resumes.

The index is converted to linear gain by a small lookup table. The table holds twelve mantissas spaced 0.5 dB apart, and the index selects one of them together with an octave shift. This approximates 6 dB as one binary octave.

Top module: `vol_ramp_ctrl`

## Requirements
- R1: While reset is held and after it is released, before any sample has arrived, `out_valid` is 0 and `out_data` is 0. The gain index of every channel resets to 255, the mute index. The first sample after reset therefore comes out as zero.
- R2: A gain index s (0 to 254) is split as s = 12q + k. The output is the input x multiplied by M[k] and shifted right arithmetically (floor) by q+7 bits, where M[k] = round(32768 * 2^(-k/12)). Index 0 is therefore a gain of 256 (+48 dB), and each index step is 0.5 dB. Index 255 always outputs 0.
- R3: The channel target is the channel code plus the master code, saturated at 255. When the channel's bypass bit is 1, the target is the channel code alone.
- R4: The scaled result saturates to the signed range of the sample width (for 16 bits, -32768 to 32767). It never wraps.
- R5: When the target index is above the current index (gain going down), the index rises by exactly one on each step sample and is otherwise unchanged.
- R6: When the target index is below the current index (gain going up), the behaviour depends on `ramp_en`. With `ramp_en`=1 the index falls by exactly one on each step sample. With `ramp_en`=0 the index takes the target value after the current sample.
- R7: A counter of valid samples starts at 0 after reset. A sample is a step sample when the count is at least (rate+1)*MULT-1. The count then restarts at 0; otherwise it increments.
- R8: Soft mute, from the master bit or the channel bit, sets the target to 255. The gain then ramps down as in R5.
- R9: A sample received while hard mute is asserted, from the master bit or the channel bit, outputs 0. The index is set to 255 after that sample, so the gain ramps back up after the mute is released.
- R10: With `zd_en`=1, a channel that has received ZD_LEN consecutive zero samples has its index set to 255 after that sample. Any nonzero sample clears the run count.
- R11: Each valid sample produces `out_valid`=1 and its scaled data one clock later, using the gain index held before that sample's update. `out_valid` is 0 in the cycle after a cycle with no valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe for all channels |
| in_data | input | NCH*DW | Signed samples, channel 0 in the low bits |
| mvol | input | 8 | Master attenuation code, 0.5 dB per count |
| cvol | input | NCH*8 | Channel volume codes, 0 = +48 dB, 0.5 dB per count |
| vol_bypass | input | NCH | Ignore the master code for this channel |
| ramp_en | input | 1 | Ramp gain increases instead of jumping |
| rate | input | 5 | Ramp pace field |
| mute_soft_all | input | 1 | Soft mute on every channel |
| mute_hard_all | input | 1 | Hard mute on every channel |
| mute_soft_ch | input | NCH | Per-channel soft mute |
| mute_hard_ch | input | NCH | Per-channel hard mute |
| zd_en | input | 1 | Enable zero-detect mute |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | NCH*DW | Scaled signed samples |

## Verification
The conversion is swept over every gain index with a fixed positive and a fixed negative sample. This separates errors in the mantissa table from errors in the octave shift, and exposes sign handling in the shift and saturation at the high-gain end. A stepped pseudo-random sample pattern at mid gains checks that the scaling is independent of the data. Master/channel combinations with mixed bypass, including sums beyond 255, tell the offset addition apart from its saturation. Rate changes, slow and fast ramps in both directions, the soft and hard mutes, and zero runs both shorter and longer than the detect length tell apart the ramp pacing, the jump path, the mute forcing and the zero-run counter.

// File: rtl/vr_pkg.sv
package vr_pkg;
  localparam int VOLW = 8;
  localparam int MANTW = 16;
  localparam logic [VOLW-1:0] MUTE_IDX = 8'hFF;

  // mantissa for fractional octave position k (0..11), 1.0 = 32768
  function automatic logic [MANTW-1:0] mant_of(input logic [3:0] k);
    logic [MANTW-1:0] m;
    case (k)
      4'd0:    m = 16'd32768;
      4'd1:    m = 16'd30929;
      4'd2:    m = 16'd29193;
      4'd3:    m = 16'd27554;
      4'd4:    m = 16'd26008;
      4'd5:    m = 16'd24548;
      4'd6:    m = 16'd23170;
      4'd7:    m = 16'd21870;
      4'd8:    m = 16'd20643;
      4'd9:    m = 16'd19484;
      4'd10:   m = 16'd18390;
      default: m = 16'd17358;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/vr_tick.sv
module vr_tick #(
  parameter int MULT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [4:0] rate,
  output logic       step
);
  localparam int CW = $clog2(32 * MULT) + 1;

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = CW'(({1'b0, rate} + 6'd1) * MULT) - CW'(1);
    step  = in_valid && (cnt_q >= lim);
    cnt_d = cnt_q;
    if (in_valid) begin
      if (step) cnt_d = '0;
      else      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/vr_chan.sv
module vr_chan
  import vr_pkg::*;
#(
  parameter int DW     = 16,
  parameter int ZD_LEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            step,
  input  logic [DW-1:0]   x,
  input  logic [VOLW-1:0] mvol,
  input  logic [VOLW-1:0] cvol,
  input  logic            bypass,
  input  logic            ramp_en,
  input  logic            smute,
  input  logic            hmute,
  input  logic            zd_en,
  output logic [DW-1:0]   y
);
  localparam int PW = DW + MANTW + 1;
  localparam int ZW = $clog2(ZD_LEN + 1);
  localparam logic [ZW-1:0] ZD_MAX = ZW'(ZD_LEN);
  localparam logic signed [PW-1:0] YMAX = PW'((2 ** (DW - 1)) - 1);
  localparam logic signed [PW-1:0] YMIN = -YMAX - PW'(1);

  logic [VOLW-1:0]        cur_q, cur_d, tgt;
  logic [VOLW:0]          sum;
  logic [ZW-1:0]          zc_q, zc_d;
  logic                   zero_in, zd_hit;
  logic [4:0]             oct;
  logic [3:0]             frac;
  logic [MANTW-1:0]       mant;
  logic signed [PW-1:0]   prod, shr;
  logic [DW-1:0]          ysc, y_d, y_q;

  // target from master offset and channel code
  always_comb begin
    sum = {1'b0, cvol} + (bypass ? {(VOLW+1){1'b0}} : {1'b0, mvol});
    if (smute || sum[VOLW]) tgt = MUTE_IDX;
    else                    tgt = sum[VOLW-1:0];
  end

  // zero-run detector
  always_comb begin
    zero_in = (x == '0);
    zc_d    = zc_q;
    if (in_valid) begin
      if (!zero_in)            zc_d = '0;
      else if (zc_q != ZD_MAX) zc_d = zc_q + ZW'(1);
    end
    zd_hit = in_valid && zd_en && zero_in && (zc_d == ZD_MAX);
  end

  // gain index ramp
  always_comb begin
    cur_d = cur_q;
    if (in_valid) begin
      if (hmute || zd_hit) begin
        cur_d = MUTE_IDX;
      end else if (tgt < cur_q) begin
        if (!ramp_en)  cur_d = tgt;
        else if (step) cur_d = cur_q - 8'd1;
      end else if (tgt > cur_q) begin
        if (step) cur_d = cur_q + 8'd1;
      end
    end
  end

  // index to linear gain and scaling
  always_comb begin
    oct  = 5'(cur_q / 8'd12);
    frac = 4'(cur_q % 8'd12);
    mant = mant_of(frac);
    prod = PW'($signed(x)) * PW'($signed({1'b0, mant}));
    shr  = prod >>> (oct + 5'd7);
    if (shr > YMAX)      ysc = YMAX[DW-1:0];
    else if (shr < YMIN) ysc = YMIN[DW-1:0];
    else                 ysc = shr[DW-1:0];
    y_d = y_q;
    if (in_valid) begin
      if (hmute || (cur_q == MUTE_IDX)) y_d = '0;
      else                              y_d = ysc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= MUTE_IDX;
      zc_q  <= '0;
      y_q   <= '0;
    end else begin
      cur_q <= cur_d;
      zc_q  <= zc_d;
      y_q   <= y_d;
    end
  end

  assign y = y_q;

  // R5
  dn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q > $past(cur_q)) && !$past(hmute) && !$past(zd_hit)
      |-> cur_q == $past(cur_q) + 8'd1);

  // R6
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q < $past(cur_q)) && $past(ramp_en)
      |-> cur_q == $past(cur_q) - 8'd1);

  // R9
  hmute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && hmute) |-> (y_q == '0));

  // R2
  mute_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && (cur_q == MUTE_IDX)) |-> (y_q == '0));
endmodule

// File: rtl/vol_ramp_ctrl.sv
module vol_ramp_ctrl
  import vr_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DW     = 16,
  parameter int MULT   = 1,
  parameter int ZD_LEN = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [NCH*DW-1:0]   in_data,
  input  logic [VOLW-1:0]     mvol,
  input  logic [NCH*VOLW-1:0] cvol,
  input  logic [NCH-1:0]      vol_bypass,
  input  logic                ramp_en,
  input  logic [4:0]          rate,
  input  logic                mute_soft_all,
  input  logic                mute_hard_all,
  input  logic [NCH-1:0]      mute_soft_ch,
  input  logic [NCH-1:0]      mute_hard_ch,
  input  logic                zd_en,
  output logic                out_valid,
  output logic [NCH*DW-1:0]   out_data
);
  logic step;
  logic vld_q, vld_d;

  vr_tick #(.MULT(MULT)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .rate     (rate),
    .step     (step)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    vr_chan #(.DW(DW), .ZD_LEN(ZD_LEN)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .step     (step),
      .x        (in_data[c*DW +: DW]),
      .mvol     (mvol),
      .cvol     (cvol[c*VOLW +: VOLW]),
      .bypass   (vol_bypass[c]),
      .ramp_en  (ramp_en),
      .smute    (mute_soft_all | mute_soft_ch[c]),
      .hmute    (mute_hard_all | mute_hard_ch[c]),
      .zd_en    (zd_en),
      .y        (out_data[c*DW +: DW])
    );
  end

  always_comb vld_d = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign out_valid = vld_q;
endmodule

// File: tb/tb_vol_ramp_ctrl.sv
module tb_vol_ramp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int DW  = 16;
  localparam int ZD  = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [NCH*DW-1:0] in_data;
  logic [7:0] mvol, cv0, cv1;
  logic [NCH*8-1:0] cvol;
  logic [1:0] byp, smc, hmc;
  logic ramp_en, sma, hma, zd_en;
  logic [4:0] rate;
  logic out_valid;
  logic [NCH*DW-1:0] out_data;

  int nchk = 0, nerr = 0;
  int m_cur[2], m_zc[2], m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;
  always_comb cvol = {cv1, cv0};

  vol_ramp_ctrl #(.NCH(NCH), .DW(DW), .MULT(1), .ZD_LEN(ZD)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .mvol(mvol), .cvol(cvol), .vol_bypass(byp), .ramp_en(ramp_en),
    .rate(rate), .mute_soft_all(sma), .mute_hard_all(hma),
    .mute_soft_ch(smc), .mute_hard_ch(hmc), .zd_en(zd_en),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_scale(input int x, input int s);
    int q, k, m;
    longint p;
    if (s == 255) return 0;
    q = s / 12;
    k = s % 12;
    m = $rtoi($pow(2.0, -k / 12.0) * 32768.0 + 0.5);
    p = longint'(x) * m;
    p = p >>> (q + 7);
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  function automatic int pat(input int i, input int ch);
    logic [15:0] v;
    v = 16'(i * 12345 + 6789 + ch * 40503);
    return int'($signed(v));
  endfunction

  task automatic send(input int x0, input int x1, input string tag);
    int xs[2], e[2];
    int lim, sum, tgt, cv;
    bit tick, hm, sm, bp, zh;
    xs[0] = x0; xs[1] = x1;
    in_data  = {16'(x1), 16'(x0)};
    in_valid = 1'b1;
    lim  = int'(rate);
    tick = (m_cnt >= lim);
    m_cnt = tick ? 0 : m_cnt + 1;
    for (int ch = 0; ch < 2; ch++) begin
      hm = hma | hmc[ch];
      sm = sma | smc[ch];
      bp = byp[ch];
      cv = (ch == 0) ? int'(cv0) : int'(cv1);
      e[ch] = hm ? 0 : exp_scale(xs[ch], m_cur[ch]);
      sum = cv + (bp ? 0 : int'(mvol));
      tgt = sm ? 255 : ((sum > 255) ? 255 : sum);
      if (xs[ch] == 0) m_zc[ch] = (m_zc[ch] < ZD) ? m_zc[ch] + 1 : ZD;
      else             m_zc[ch] = 0;
      zh = zd_en && (xs[ch] == 0) && (m_zc[ch] >= ZD);
      if (hm || zh) m_cur[ch] = 255;
      else if (tgt < m_cur[ch]) begin
        if (!ramp_en) m_cur[ch] = tgt;
        else if (tick) m_cur[ch] = m_cur[ch] - 1;
      end else if (tgt > m_cur[ch]) begin
        if (tick) m_cur[ch] = m_cur[ch] + 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11", int'(out_valid), 1);
    chk(tag, int'($signed(out_data[15:0])), e[0]);
    chk(tag, int'($signed(out_data[31:16])), e[1]);
  endtask

  task automatic send_pat(input int n, input string tag);
    for (int i = 0; i < n; i++) send(pat(i, 0), pat(i, 1), tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    #(CLK_PERIOD * 180000);
    nchk++;
    nerr++;
    $display("FAIL R11: watchdog expired, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    mvol = 8'd0; cv0 = 8'd0; cv1 = 8'd0; byp = 2'b00;
    ramp_en = 1'b0; rate = 5'd0; sma = 1'b0; hma = 1'b0;
    smc = 2'b00; hmc = 2'b00; zd_en = 1'b0;
    m_cur[0] = 255; m_cur[1] = 255; m_zc[0] = 0; m_zc[1] = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    chk("R1", int'(out_valid), 0);
    chk("R1", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", int'(out_valid), 0);
    chk("R1", int'(out_data), 0);
    cv0 = 8'd20; cv1 = 8'd20; byp = 2'b11;
    send(1000, -1000, "R1");

    // exhaustive index sweep with fixed samples
    for (int s = 0; s < 255; s++) begin
      cv0 = 8'(s); cv1 = 8'(s);
      send(30000, -12345, (s < 16) ? "R4" : "R2");
      send(30000, -12345, (s < 16) ? "R4" : "R2");
    end
    cv0 = 8'd24; cv1 = 8'd40;
    send_pat(300, "R2");
    cv0 = 8'd0; cv1 = 8'd3;
    send_pat(40, "R4");

    // master/channel combinations
    byp = 2'b00; mvol = 8'd10; cv0 = 8'd20; cv1 = 8'd70;
    send_pat(260, "R3");
    mvol = 8'd200; cv0 = 8'd100; cv1 = 8'd55;
    send_pat(260, "R3");
    byp = 2'b01; mvol = 8'd128; cv0 = 8'd127; cv1 = 8'd127;
    send_pat(260, "R3");
    byp = 2'b10; mvol = 8'd60; cv0 = 8'd30; cv1 = 8'd30;
    send_pat(260, "R3");
    byp = 2'b11; mvol = 8'd0;

    // ramp pacing, gain going down
    cv0 = 8'd10; cv1 = 8'd10;
    send_pat(5, "R6");
    rate = 5'd3; cv0 = 8'd60; cv1 = 8'd30;
    send_pat(250, "R5");
    rate = 5'd7; cv0 = 8'd72; cv1 = 8'd45;
    send_pat(150, "R7");
    rate = 5'd1;
    send_pat(30, "R7");

    // gain going up, ramped and jumping
    ramp_en = 1'b1; rate = 5'd2; cv0 = 8'd5; cv1 = 8'd0;
    send_pat(250, "R6");
    rate = 5'd0; cv0 = 8'd40; cv1 = 8'd40;
    send_pat(60, "R6");
    ramp_en = 1'b0; cv0 = 8'd2; cv1 = 8'd3;
    send_pat(5, "R6");

    // soft mutes
    ramp_en = 1'b1; rate = 5'd0; sma = 1'b1;
    send_pat(270, "R8");
    sma = 1'b0; smc = 2'b10;
    send_pat(270, "R8");
    smc = 2'b00;
    send_pat(20, "R8");

    // hard mutes
    hmc = 2'b01;
    send_pat(5, "R9");
    hmc = 2'b00;
    send_pat(30, "R9");
    hma = 1'b1;
    send_pat(3, "R9");
    hma = 1'b0;
    send_pat(20, "R9");

    // zero-detect mute
    ramp_en = 1'b0; cv0 = 8'd12; cv1 = 8'd30;
    send_pat(3, "R10");
    zd_en = 1'b1;
    for (int i = 0; i < ZD - 1; i++) send(0, 0, "R10");
    send_pat(10, "R10");
    for (int i = 0; i < ZD + 6; i++) send(0, (i == 3) ? 500 : 0, "R10");
    ramp_en = 1'b1; rate = 5'd1;
    send_pat(80, "R10");

    @(negedge clk);
    chk("R11", int'(out_valid), 0);
    summary();
    $finish;
  end
endmodule